// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Unit

This block watches three asynchronous external interrupt pins. Each pin passes through a synchroniser and then an edge detector. The detector fires on a rising or a falling transition, as chosen by that pin's own polarity bit. A detected edge sets a pending flag for the pin. The flag stays set until software pulses that pin's clear strobe. Each pin's interrupt request is its flag gated by its enable bit, so a masked pin still records its event.

A sleep/idle indicator from the power controller turns on the wake-up path. While the indicator is high, the first detected edge on a pin that was enabled before the indicator rose produces a one-cycle wake-up pulse. Every source also carries a fixed priority tag. Pin 0 is always high priority. Pins 1 and 2 take their tag from a priority-select input. Arbitration between sources and vectoring happen downstream.

Top module: `ext_irq_unit`

## Requirements
- R1: With `edge_rise[i]`=1 a 0-to-1 transition on `pin_in[i]` is a valid edge; with `edge_rise[i]`=0 only a 1-to-0 transition is valid; the transition in the other direction leaves the flag unchanged.
- R2: A valid edge sets `pend_flag[i]`. The flag is visible in the third clock cycle after the pin changes (two synchroniser flops, then the flag register).
- R3: `irq_req[i]` is 1 exactly when `pend_flag[i]` and `irq_en[i]` are both 1; with `irq_en[i]`=0 the flag is still latched.
- R4: Once set, `pend_flag[i]` stays 1 until `flag_clr[i]` is pulsed, whatever further edges or enable changes occur.
- R5: `flag_clr[i]`=1 for one cycle clears `pend_flag[i]` on the next clock edge. If a valid edge on the same pin lands in that same cycle, the flag stays 1.
- R6: `irq_hi_prio[0]` is always 1; `irq_hi_prio[i]` for i=1,2 equals `prio_sel[i]` (1 = high, 0 = low).
- R7: `wake_pulse` is a one-cycle pulse, issued in the same cycle the flag rises, for the first valid edge while `sleep_mode`=1 on a pin whose `irq_en` was 1 in the last cycle before `sleep_mode` rose. Later edges in the same sleep period, edges on pins that were not armed, and edges while awake give no pulse.
- R8: After reset all flags, requests and `wake_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 3 | Asynchronous external interrupt pins |
| edge_rise | input | 3 | Per-pin polarity: 1 rising, 0 falling |
| irq_en | input | 3 | Per-pin interrupt enable |
| flag_clr | input | 3 | Per-pin software clear strobe |
| prio_sel | input | 2 | Priority bits for pins 2..1 (1 = high) |
| sleep_mode | input | 1 | High while the device is in sleep or idle |
| pend_flag | output | 3 | Sticky pending flags |
| irq_req | output | 3 | Enabled interrupt requests |
| irq_hi_prio | output | 3 | Per-source priority tag (1 = high) |
| wake_pulse | output | 1 | One-cycle wake-up pulse |

## Verification
Two events can reach the same flag register in the same cycle: a software clear and a freshly detected edge. The bench forces this case. It changes a pin whose flag is already set. After the second synchroniser edge, while the edge detector is active, it raises the clear strobe for exactly one cycle. The flag must read 1 afterwards. A clear issued one cycle earlier or later must leave the flag at 0 or 1 as the edge timing dictates. The wake logic shares the same edge cycle with the flag set, so that pulse is sampled in the same cycle as the flag.

// File: rtl/ext_irq_pkg.sv
// Shared definitions for the external interrupt unit.
package ext_irq_pkg;
    // Number of external interrupt pins handled by the unit.
    localparam int unsigned EXT_IRQ_PINS = 3;

    // Meaning of a polarity bit.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/irq_pin_sync.sv
// Synchroniser and edge detector for one asynchronous interrupt pin.
// The pin passes through SYNC_STAGES flops. A further flop keeps the previous
// synchronised level, and an edge is the difference between the two.
// Assumes SYNC_STAGES >= 2. Edges are suppressed until the pipeline has been
// refilled after reset, so a pin held high through reset gives no edge.
module irq_pin_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_hit
);
    import ext_irq_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [SYNC_STAGES:0]   fill_q;
    logic                   level;
    logic                   rise_ev;
    logic                   fall_ev;

    // Shift the pin into the synchroniser chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Mark when the chain holds only samples taken after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= {fill_q[SYNC_STAGES-1:0], 1'b1};
    end

    // Select the wanted edge direction.
    always_comb begin
        level    = sync_q[SYNC_STAGES-1];
        rise_ev  = level & ~prev_q;
        fall_ev  = ~level & prev_q;
        edge_hit = fill_q[SYNC_STAGES] &
                   ((edge_pol_e'(rise_sel) == EDGE_RISE) ? rise_ev : fall_ev);
    end
endmodule

// File: rtl/irq_pend_cell.sv
// Sticky pending flag for one source. A detected edge sets it. A software
// clear resets it. An edge in the same cycle as a clear takes precedence.
module irq_pend_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag
);
    logic flag_q;

    // Set has priority over clear; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_ev) flag_q <= 1'b1;
        else if (clr_ev) flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/irq_wake_ctrl.sv
// Wake-up pulse generator. The enables are sampled while awake and frozen
// while the sleep indicator is high, so only pins enabled before sleep began
// can wake the device. One pulse is issued per sleep period.
module irq_wake_ctrl #(
    parameter int unsigned NUM_PINS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_mode,
    input  logic [NUM_PINS-1:0] irq_en,
    input  logic [NUM_PINS-1:0] edge_hit,
    output logic                wake_pulse
);
    logic [NUM_PINS-1:0] armed_q;
    logic                woke_q;
    logic                pulse_q;
    logic                fire;

    // A wake event: sleeping, not yet woken, and an armed pin saw an edge.
    assign fire = sleep_mode & ~woke_q & (|(edge_hit & armed_q));

    // Track the enables while awake and freeze them during sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_q <= '0;
        else if (!sleep_mode) armed_q <= irq_en;
    end

    // Remember that this sleep period has already produced a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          woke_q <= 1'b0;
        else if (!sleep_mode) woke_q <= 1'b0;
        else if (fire)        woke_q <= 1'b1;
    end

    // Register the pulse so it lines up with the flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= fire;
    end

    assign wake_pulse = pulse_q;
endmodule

// File: rtl/ext_irq_unit.sv
// External interrupt unit: per-pin synchroniser, edge select, sticky flag,
// enable masking, priority tag and a wake-up pulse. Pin 0 is fixed high
// priority; the other pins take their tag from prio_sel.
module ext_irq_unit #(
    parameter int unsigned NUM_PINS    = ext_irq_pkg::EXT_IRQ_PINS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] edge_rise,
    input  logic [NUM_PINS-1:0] irq_en,
    input  logic [NUM_PINS-1:0] flag_clr,
    input  logic [NUM_PINS-1:1] prio_sel,
    input  logic                sleep_mode,
    output logic [NUM_PINS-1:0] pend_flag,
    output logic [NUM_PINS-1:0] irq_req,
    output logic [NUM_PINS-1:0] irq_hi_prio,
    output logic                wake_pulse
);
    logic [NUM_PINS-1:0] edge_hit;

    // One detector, one flag and one priority tag per pin.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        irq_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_async(pin_in[i]),
            .rise_sel (edge_rise[i]),
            .edge_hit (edge_hit[i])
        );

        irq_pend_cell u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_ev(edge_hit[i]),
            .clr_ev(flag_clr[i]),
            .flag  (pend_flag[i])
        );

        if (i == 0) begin : g_fixed
            assign irq_hi_prio[i] = 1'b1;
        end else begin : g_sel
            assign irq_hi_prio[i] = prio_sel[i];
        end
    end

    // Requests are flags gated by their enables.
    assign irq_req = pend_flag & irq_en;

    irq_wake_ctrl #(.NUM_PINS(NUM_PINS)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_mode(sleep_mode),
        .irq_en    (irq_en),
        .edge_hit  (edge_hit),
        .wake_pulse(wake_pulse)
    );
endmodule

// File: rtl/ext_irq_chk.sv
// Temporal checks for ext_irq_unit, attached by bind.
module ext_irq_chk #(
    parameter int unsigned NUM_PINS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] edge_hit,
    input logic [NUM_PINS-1:0] flag_clr,
    input logic [NUM_PINS-1:0] pend_flag,
    input logic                sleep_mode,
    input logic                wake_pulse
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R4: a set flag without a clear stays set.
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_flag[i] && !flag_clr[i]) |=> pend_flag[i]);

        // R2: a flag only rises after a detected edge.
        p_set_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_flag[i]) |-> $past(edge_hit[i]));

        // R5: a flag only falls after a clear strobe.
        p_clear_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_flag[i]) |-> $past(flag_clr[i]));

        // R5: an edge together with a clear leaves the flag set.
        p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_hit[i] && flag_clr[i]) |=> pend_flag[i]);
    end

    // R7: the wake pulse lasts one cycle.
    p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R7: the wake pulse follows an edge seen during sleep.
    p_wake_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(sleep_mode) && ($past(edge_hit) != '0)));
endmodule

bind ext_irq_unit ext_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_hit  (edge_hit),
    .flag_clr  (flag_clr),
    .pend_flag (pend_flag),
    .sleep_mode(sleep_mode),
    .wake_pulse(wake_pulse)
);

// File: tb/test_ext_irq_unit.sv
`timescale 1ns/1ps
module test_ext_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_in = '0;
    logic [2:0] edge_rise = '0;
    logic [2:0] irq_en = '0;
    logic [2:0] flag_clr = '0;
    logic [2:1] prio_sel = '0;
    logic       sleep_mode = 1'b0;
    logic [2:0] pend_flag;
    logic [2:0] irq_req;
    logic [2:0] irq_hi_prio;
    logic       wake_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ext_irq_unit i_ext_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_rise(edge_rise),
        .irq_en(irq_en), .flag_clr(flag_clr), .prio_sel(prio_sel),
        .sleep_mode(sleep_mode), .pend_flag(pend_flag), .irq_req(irq_req),
        .irq_hi_prio(irq_hi_prio), .wake_pulse(wake_pulse)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Drive a pin at a negedge and wait until the flag would be visible.
    task automatic drive_pin(int i, logic v);
        pin_in[i] = v;
        cyc(3);
    endtask

    task automatic clear_pin(int i);
        flag_clr[i] = 1'b1;
        cyc(1);
        flag_clr[i] = 1'b0;
    endtask

    // Count wake pulses over n cycles, sampled at negedges.
    task automatic watch_wake(int n, output int seen);
        seen = 0;
        for (int k = 0; k < n; k++) begin
            cyc(1);
            if (wake_pulse) seen++;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen;
        @(negedge clk);
        cyc(3);
        rst_n = 1'b1;
        cyc(5);
        // R8: reset state
        check("R8 flags", pend_flag, 3'b000);
        check("R8 req", irq_req, 3'b000);
        check("R8 wake", wake_pulse, 1'b0);

        // R6: priority tags for every prio_sel value
        for (int p = 0; p < 4; p++) begin
            prio_sel = p[1:0];
            cyc(1);
            check("R6 prio", irq_hi_prio, {p[1:0], 1'b1});
        end

        // R1/R2/R3: sweep pin, polarity, start level and enable
        for (int i = 0; i < 3; i++)
            for (int pol = 0; pol < 2; pol++)
                for (int st = 0; st < 2; st++)
                    for (int en = 0; en < 2; en++) begin
                        logic exp_f;
                        pin_in[i] = st[0];
                        cyc(4);
                        clear_pin(i);
                        check("R5 pre-clear", pend_flag[i], 1'b0);
                        edge_rise[i] = pol[0];
                        irq_en[i] = en[0];
                        pin_in[i] = ~st[0];
                        cyc(2);
                        check("R2 latency", pend_flag[i], 1'b0);
                        cyc(1);
                        exp_f = (pol[0] == ~st[0]);
                        check("R1 edge select", pend_flag[i], exp_f);
                        check("R3 masking", irq_req[i], exp_f & en[0]);
                        check("R3 others", pend_flag & ~(3'b1 << i), 3'b000);
                        irq_en[i] = 1'b1;
                        cyc(1);
                        check("R3 enable late", irq_req[i], exp_f);
                        irq_en[i] = 1'b0;
                        clear_pin(i);
                        check("R5 clear", pend_flag[i], 1'b0);
                        pin_in[i] = 1'b0;
                        cyc(4);
                        clear_pin(i);
                    end

        // R4: sticky under further edges and enable changes
        edge_rise = 3'b111;
        drive_pin(1, 1'b1);
        check("R4 set", pend_flag[1], 1'b1);
        drive_pin(1, 1'b0);
        irq_en[1] = 1'b1;
        cyc(2);
        irq_en[1] = 1'b0;
        drive_pin(1, 1'b1);
        cyc(10);
        check("R4 sticky", pend_flag[1], 1'b1);

        // R5: clear in the same cycle as a new edge; flag already set
        pin_in[1] = 1'b0;
        cyc(4);
        pin_in[1] = 1'b1;
        cyc(2);
        flag_clr[1] = 1'b1;
        cyc(1);
        flag_clr[1] = 1'b0;
        check("R5 edge wins", pend_flag[1], 1'b1);
        // clear one cycle after the edge cycle clears it
        pin_in[1] = 1'b0;
        cyc(4);
        pin_in[1] = 1'b1;
        cyc(3);
        clear_pin(1);
        check("R5 late clear", pend_flag[1], 1'b0);
        pin_in = 3'b000;
        cyc(4);
        clear_pin(0); clear_pin(1); clear_pin(2);

        // R7: pin 1 armed before sleep, enable dropped during sleep
        irq_en = 3'b010;
        cyc(1);
        sleep_mode = 1'b1;
        cyc(1);
        irq_en = 3'b000;
        pin_in[1] = 1'b1;
        cyc(3);
        check("R7 wake", wake_pulse, 1'b1);
        check("R7 flag same cycle", pend_flag[1], 1'b1);
        cyc(1);
        check("R7 single", wake_pulse, 1'b0);
        pin_in[1] = 1'b0;
        cyc(4);
        pin_in[1] = 1'b1;
        watch_wake(6, seen);
        check("R7 once per sleep", seen, 0);
        sleep_mode = 1'b0;
        pin_in = 3'b000;
        cyc(4);
        clear_pin(1);

        // R7: enabled only after sleep began -> no wake, flag still set
        sleep_mode = 1'b1;
        cyc(1);
        irq_en = 3'b111;
        pin_in[2] = 1'b1;
        watch_wake(6, seen);
        check("R7 not armed", seen, 0);
        check("R7 flag without wake", pend_flag[2], 1'b1);
        sleep_mode = 1'b0;
        pin_in = 3'b000;
        cyc(4);
        clear_pin(2);

        // R7: edge while awake -> no wake
        pin_in[0] = 1'b1;
        watch_wake(6, seen);
        check("R7 awake", seen, 0);

        // R7: new sleep period re-arms
        pin_in[0] = 1'b0;
        cyc(4);
        sleep_mode = 1'b1;
        cyc(1);
        pin_in[0] = 1'b1;
        watch_wake(6, seen);
        check("R7 re-arm", seen, 1);
        sleep_mode = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule